// File: doc/BRIEF.md
# TCP Handshake Tracker

This block follows one TCP connection through its opening handshake, data phase and teardown by watching the control flags of each packet and the side that sent it. It keeps a five-state machine: closed, SYN seen, SYN+ACK seen, established, and exchanging data. From that state it drives three signals for the stream logic further down the pipeline:

- a direction bit that steers each packet to the client or the server reassembly path;
- an alarm pulse for suspicious flag use;
- a connected indication.

It also gives a one-cycle strobe that tells the reassembly units to latch the peer's window size.

The alarm fires for two reasons. The first is a flag pattern that no well-behaved stack sends, which is typical of stealth scans. The second is a handshake that sits half-open for more packets than a programmable limit allows. In that second case the machine also gives up on the attempt and returns to closed. All outputs are registered. Each one changes on the clock edge that takes in the packet that caused the change.

Top module: `tcp_hs_tracker`

## Requirements
- R1: While reset is asserted, and after it is released with no packet seen, hs_state is 0 and established, flag_vuln, win_capture and division are all 0.
- R2: hs_state is encoded as closed=0, SYN seen=1, SYN+ACK seen=2, established=3, exchange=4. A client packet with SYN and without ACK/FIN/RST moves 0 to 1. A server packet with SYN+ACK and without FIN/RST moves 1 to 2. A client packet with ACK and without SYN/FIN/RST moves 2 to 3. In state 3, the first packet from either side with ACK and without SYN/FIN/RST moves to 4.
- R3: established is 1 exactly while hs_state is 3 or 4. It falls in the same cycle that hs_state returns to 0.
- R4: win_capture pulses for one cycle, in the cycle after the edge on which hs_state enters 2 or 3, and at no other time.
- R5: division takes the direction of the last valid packet (1 = client, 0 = server) and holds it on cycles without a valid packet.
- R6: flag_vuln pulses for one cycle after a valid packet with SYN and FIN both set, or with no flag set, or with FIN but not ACK while hs_state is 0. Such a packet does not change hs_state unless it carries RST.
- R7: In states 1 and 2, each valid packet that neither advances nor resets the machine is counted. When the number of such packets would exceed stall_limit, flag_vuln pulses and hs_state returns to 0. A limit of 0 trips on the first such packet.
- R8: A valid packet with RST returns hs_state to 0 from any state.
- R9: In state 4, teardown needs a FIN+ACK from each side. A repeated FIN from the same side keeps hs_state at 4. The FIN from the opposite side moves it to 0.
- R10: A valid packet that matches no transition leaves hs_state unchanged. A cycle without pkt_valid leaves hs_state unchanged and raises neither pulse output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | A packet header is presented this cycle |
| pkt_from_client | input | 1 | 1 = packet sent by client, 0 = by server |
| flag_syn | input | 1 | SYN flag of the packet |
| flag_ack | input | 1 | ACK flag of the packet |
| flag_fin | input | 1 | FIN flag of the packet |
| flag_rst | input | 1 | RST flag of the packet |
| stall_limit | input | STALL_W | Non-advancing packets tolerated in a half-open state |
| hs_state | output | 3 | Current handshake state, encoded as in R2 |
| division | output | 1 | Direction steering for the reassembly paths |
| flag_vuln | output | 1 | One-cycle anomaly alarm |
| established | output | 1 | Connection is up (states 3 and 4) |
| win_capture | output | 1 | Strobe to latch the peer window size |

## Verification
The hardest case to reach from the ports is the half-open timeout. The machine must be held in state 1 or 2 while exactly stall_limit packets are fed that neither advance nor reset it, and only the next such packet may trip the alarm. The stimulus table retransmits SYN and SYN+ACK and sends out-of-place client ACKs with a limit of 2. It then checks that the third stray packet, and not an earlier one, raises the alarm and closes the connection. A directed test repeats this with a limit of 0 to cover the boundary. The two-sided FIN teardown is reached by first walking the full handshake into the exchange state. After that, a duplicate FIN from one side is shown to leave the connection open.

// File: rtl/tcp_hs_pkg.sv
package tcp_hs_pkg;

  typedef enum logic [2:0] {
    HS_CLOSED   = 3'd0,
    HS_SYN_SENT = 3'd1,
    HS_SYN_RECV = 3'd2,
    HS_ESTAB    = 3'd3,
    HS_EXCH     = 3'd4
  } hs_state_e;

  typedef struct packed {
    logic syn;
    logic ack;
    logic fin;
    logic rst;
  } tcp_flags_t;

  // Flag patterns that no conforming stack emits
  function automatic logic flags_illegal(tcp_flags_t f, logic in_closed);
    return (f.syn && f.fin) || (f == 4'b0000) || (in_closed && f.fin && !f.ack);
  endfunction

  function automatic logic is_half_open(hs_state_e s);
    return (s == HS_SYN_SENT) || (s == HS_SYN_RECV);
  endfunction

  function automatic logic is_connected(hs_state_e s);
    return (s == HS_ESTAB) || (s == HS_EXCH);
  endfunction

  // Entries to these states prompt the window-size capture
  function automatic logic is_window_entry(hs_state_e s);
    return (s == HS_SYN_RECV) || (s == HS_ESTAB);
  endfunction

endpackage

// File: rtl/tcp_hs_flag_check.sv
module tcp_hs_flag_check
  import tcp_hs_pkg::*;
(
  input  logic       pkt_valid,
  input  tcp_flags_t flags,
  input  hs_state_e  state_q,
  output logic       illegal_hit
);

  assign illegal_hit = pkt_valid && flags_illegal(flags, state_q == HS_CLOSED);

endmodule

// File: rtl/tcp_hs_stall_cnt.sv
module tcp_hs_stall_cnt #(
  parameter int STALL_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               count_en,
  input  logic               clear,
  input  logic [STALL_W-1:0] limit,
  output logic               trip
);

  logic [STALL_W-1:0] cnt_q;

  // Trips on the packet that would take the count past the limit
  assign trip = count_en && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (clear)    cnt_q <= '0;
    else if (count_en) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/tcp_hs_fsm.sv
module tcp_hs_fsm
  import tcp_hs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pkt_valid,
  input  logic       from_client,
  input  tcp_flags_t flags,
  input  logic       stall_trip,
  output hs_state_e  state_q,
  output hs_state_e  state_d,
  output logic       hold_half,
  output logic       state_chg
);

  logic      advance;
  hs_state_e base_d;
  logic      fin_cli_q, fin_srv_q, fin_cli_d, fin_srv_d;

  // Transition decode, independent of the stall counter
  always_comb begin
    advance   = 1'b0;
    base_d    = state_q;
    fin_cli_d = fin_cli_q;
    fin_srv_d = fin_srv_q;
    if (pkt_valid) begin
      if (flags.rst) begin
        base_d = HS_CLOSED;
      end else begin
        unique case (state_q)
          HS_CLOSED:
            if (from_client && flags.syn && !flags.ack && !flags.fin) begin
              base_d = HS_SYN_SENT; advance = 1'b1;
            end
          HS_SYN_SENT:
            if (!from_client && flags.syn && flags.ack && !flags.fin) begin
              base_d = HS_SYN_RECV; advance = 1'b1;
            end
          HS_SYN_RECV:
            if (from_client && flags.ack && !flags.syn && !flags.fin) begin
              base_d = HS_ESTAB; advance = 1'b1;
            end
          HS_ESTAB:
            if (flags.ack && !flags.syn && !flags.fin) begin
              base_d = HS_EXCH; advance = 1'b1;
            end
          HS_EXCH:
            if (flags.fin && flags.ack && !flags.syn) begin
              if (from_client ? fin_srv_q : fin_cli_q) begin
                base_d = HS_CLOSED;
              end else if (from_client) begin
                fin_cli_d = 1'b1;
              end else begin
                fin_srv_d = 1'b1;
              end
            end
          default: base_d = HS_CLOSED;
        endcase
      end
    end
  end

  assign hold_half = pkt_valid && !flags.rst && !advance && is_half_open(state_q);
  assign state_d   = (hold_half && stall_trip) ? HS_CLOSED : base_d;
  assign state_chg = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= HS_CLOSED;
      fin_cli_q <= 1'b0;
      fin_srv_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      fin_cli_q <= (state_d == HS_EXCH) && fin_cli_d;
      fin_srv_q <= (state_d == HS_EXCH) && fin_srv_d;
    end
  end

endmodule

// File: rtl/tcp_hs_tracker.sv
module tcp_hs_tracker
  import tcp_hs_pkg::*;
#(
  parameter int STALL_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pkt_valid,
  input  logic               pkt_from_client,
  input  logic               flag_syn,
  input  logic               flag_ack,
  input  logic               flag_fin,
  input  logic               flag_rst,
  input  logic [STALL_W-1:0] stall_limit,
  output logic [2:0]         hs_state,
  output logic               division,
  output logic               flag_vuln,
  output logic               established,
  output logic               win_capture
);

  tcp_flags_t flags;
  hs_state_e  state_q, state_d;
  logic       hold_half, state_chg, stall_trip, illegal_hit;

  assign flags = '{syn: flag_syn, ack: flag_ack, fin: flag_fin, rst: flag_rst};

  tcp_hs_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .pkt_valid  (pkt_valid),
    .from_client(pkt_from_client),
    .flags      (flags),
    .stall_trip (stall_trip),
    .state_q    (state_q),
    .state_d    (state_d),
    .hold_half  (hold_half),
    .state_chg  (state_chg)
  );

  tcp_hs_stall_cnt #(.STALL_W(STALL_W)) u_stall (
    .clk     (clk),
    .rst_n   (rst_n),
    .count_en(hold_half),
    .clear   (state_chg),
    .limit   (stall_limit),
    .trip    (stall_trip)
  );

  tcp_hs_flag_check u_flags (
    .pkt_valid  (pkt_valid),
    .flags      (flags),
    .state_q    (state_q),
    .illegal_hit(illegal_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      division    <= 1'b0;
      flag_vuln   <= 1'b0;
      win_capture <= 1'b0;
    end else begin
      if (pkt_valid) division <= pkt_from_client;
      flag_vuln   <= illegal_hit || (hold_half && stall_trip);
      win_capture <= state_chg && is_window_entry(state_d);
    end
  end

  assign hs_state    = state_q;
  assign established = is_connected(state_q);

endmodule

// File: rtl/tcp_hs_checker.sv
module tcp_hs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       pkt_valid,
  input logic       pkt_from_client,
  input logic       flag_syn,
  input logic       flag_fin,
  input logic       flag_rst,
  input logic [2:0] hs_state,
  input logic       division,
  input logic       flag_vuln,
  input logic       established,
  input logic       win_capture
);

  p_state_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hs_state <= 3'd4);

  p_rst_close_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && flag_rst) |=> (hs_state == 3'd0));

  p_est_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(established) |-> (hs_state == 3'd3) && ($past(hs_state) == 3'd2));

  p_est_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(established) |-> (hs_state == 3'd0));

  p_win_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    win_capture |-> ((hs_state == 3'd2) || (hs_state == 3'd3)) && ($past(hs_state) != hs_state));

  p_div_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |=> (division == $past(pkt_from_client)));

  p_synfin_alarm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && flag_syn && flag_fin) |=> flag_vuln);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_valid |=> $stable(hs_state) && !flag_vuln && !win_capture);

endmodule

bind tcp_hs_tracker tcp_hs_checker u_chk (.*);

// File: tb/tb_tcp_hs_tracker.sv
module tb_tcp_hs_tracker;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pkt_valid = 1'b0, pkt_from_client = 1'b0;
  logic       flag_syn = 1'b0, flag_ack = 1'b0, flag_fin = 1'b0, flag_rst = 1'b0;
  logic [7:0] stall_limit = 8'd2;
  logic [2:0] hs_state;
  logic       division, flag_vuln, established, win_capture;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #2 clk = ~clk;

  tcp_hs_tracker #(.STALL_W(8)) dut (.*);

  // {valid, client, syn, ack, fin, rst, state[2:0], est, vuln, win, div}
  localparam int NV = 21;
  localparam logic [12:0] VEC [NV] = '{
    13'b1_1_1_0_0_0_001_0_0_0_1,
    13'b1_1_1_0_0_0_001_0_0_0_1,
    13'b1_0_1_1_0_0_010_0_0_1_0,
    13'b1_0_1_1_0_0_010_0_0_0_0,
    13'b1_1_0_1_0_0_011_1_0_1_1,
    13'b0_0_0_0_0_0_011_1_0_0_1,
    13'b1_0_0_1_0_0_100_1_0_0_0,
    13'b1_1_0_1_1_0_100_1_0_0_1,
    13'b1_1_0_1_1_0_100_1_0_0_1,
    13'b1_0_0_1_1_0_000_0_0_0_0,
    13'b1_1_1_0_1_0_000_0_1_0_1,
    13'b1_0_0_0_0_0_000_0_1_0_0,
    13'b1_1_0_0_1_0_000_0_1_0_1,
    13'b1_1_0_1_1_0_000_0_0_0_1,
    13'b1_1_1_0_0_0_001_0_0_0_1,
    13'b1_1_0_1_0_0_001_0_0_0_1,
    13'b1_1_0_1_0_0_001_0_0_0_1,
    13'b1_1_0_1_0_0_000_0_1_0_1,
    13'b1_1_1_0_0_0_001_0_0_0_1,
    13'b1_0_1_1_0_0_010_0_0_1_0,
    13'b1_0_0_0_0_1_000_0_0_0_0
  };

  function automatic string row_tag(int i);
    case (i)
      1, 3:           return "R10";
      2, 19:          return "R4";
      4:              return "R3";
      5:              return "R5";
      7, 8, 9:        return "R9";
      10, 11, 12, 13: return "R6";
      15, 16, 17:     return "R7";
      20:             return "R8";
      default:        return "R2";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag, input int st, input int est,
                           input int vu, input int wn, input int dv);
    chk(tag, "hs_state",    hs_state,    st);
    chk(tag, "established", established, est);
    chk(tag, "flag_vuln",   flag_vuln,   vu);
    chk(tag, "win_capture", win_capture, wn);
    chk(tag, "division",    division,    dv);
  endtask

  // Called 1 ns after a rising edge; results are read 1 ns after the next one
  task automatic send(input logic v, input logic c, input logic s,
                      input logic a, input logic f, input logic r);
    pkt_valid = v; pkt_from_client = c;
    flag_syn = s; flag_ack = a; flag_fin = f; flag_rst = r;
    @(posedge clk); #1;
    pkt_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    check_all("R1", 0, 0, 0, 0, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check_all("R1", 0, 0, 0, 0, 0);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i][12], VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7]);
      check_all(row_tag(i), int'(VEC[i][6:4]), VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R7 boundary: a limit of 0 trips on the first stray packet
    stall_limit = 8'd0;
    send(1, 1, 1, 0, 0, 0);
    chk("R7", "hs_state", hs_state, 1);
    send(1, 0, 0, 1, 0, 0);
    chk("R7", "hs_state", hs_state, 0);
    chk("R7", "flag_vuln", flag_vuln, 1);
    stall_limit = 8'd2;

    // R8 / R3: RST in exchange drops established on the same cycle
    send(1, 1, 1, 0, 0, 0);
    send(1, 0, 1, 1, 0, 0);
    send(1, 1, 0, 1, 0, 0);
    send(1, 1, 0, 1, 0, 0);
    chk("R2", "hs_state", hs_state, 4);
    send(1, 1, 1, 1, 1, 0);
    chk("R6", "hs_state", hs_state, 4);
    chk("R6", "flag_vuln", flag_vuln, 1);
    send(1, 0, 0, 1, 0, 1);
    chk("R8", "hs_state", hs_state, 0);
    chk("R3", "established", established, 0);

    // R10: idle cycles leave state and pulses alone
    send(1, 1, 1, 0, 0, 0);
    send(0, 0, 0, 0, 0, 0);
    send(0, 0, 0, 0, 0, 0);
    chk("R10", "hs_state", hs_state, 1);
    chk("R10", "flag_vuln", flag_vuln, 0);

    // R1: reset mid-connection
    send(1, 0, 1, 1, 0, 0);
    send(1, 1, 0, 1, 0, 0);
    chk("R3", "established", established, 1);
    rst_n = 1'b0;
    #1;
    check_all("R1", 0, 0, 0, 0, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule